// File: doc/BRIEF.md
# Interleaved Two-Bank Flash Read Controller

This block connects a 32-bit on-chip read port to a flash array that is split into two banks. Even word addresses are stored in one bank and odd word addresses in the other, and each bank has its own read port. Both banks can therefore be addressed in the same cycle. While the word asked for now is being read from one bank, the next word in sequence can already be addressed in the other bank.

A master presents `req_addr` with `req_valid` and holds both until `rsp_ready` is high. In that same cycle `rsp_data` carries the word. The `req_seq` hint tells the controller that the master expects to read the following word next. The `cfg_wait1` input selects how fast the flash is. With 0 the flash needs no wait state and every access finishes in its first cycle. With 1 the flash needs its address held for one edge before the data is valid. In that case an ordinary access takes two cycles, but a word that was prefetched in the other bank is returned in one cycle. A sequential burst therefore runs at one word per clock.

Top module: `ilv_flash_rd`

## Requirements
- R1: `rsp_ready` is low whenever `req_valid` is low, including throughout reset and in every cycle after reset until the first request.
- R2: With `cfg_wait1`=0, `rsp_ready` is high in the first cycle of every request, and `rsp_data` is the addressed word.
- R3: Byte address bit 2 selects the bank (0 selects bank 0, 1 selects bank 1). The row inside the bank is `req_addr[ADDR_W-1:3]`. The data returned comes from that bank at that row.
- R4: With `cfg_wait1`=1, a request that does not hit a prefetch has `rsp_ready` low in its first cycle and high in its second cycle.
- R5: With `cfg_wait1`=1, a request completed with `req_seq`=1 makes the other bank present the next word. A following request at the previous address plus 4 then completes in its first cycle, so a burst delivers one word per clock after the first. This holds whether the burst starts in bank 0 or bank 1.
- R6: A prefetched word is used only when the new address equals the previous address plus 4. A repeat of the same address, or any other address, takes two cycles.
- R7: A request that misses the prefetch discards it. After such a miss completes with `req_seq`=0, a request to the formerly prefetched address takes two cycles.
- R8: A request completed with `req_seq`=0 sets up no prefetch, so the next sequential request takes two cycles.
- R9: With `cfg_wait1`=1, in every cycle where `rsp_ready` is high, the bank being read has been enabled and has presented the same row since the previous cycle.
- R10: Idle cycles (`req_valid` low) between the words of a burst do not discard the prefetch. The bank rows are held while idle.
- R11: With `cfg_wait1`=0, no prefetch is recorded. After switching to `cfg_wait1`=1, a sequential request takes two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wait1 | input | 1 | Flash wait-state setting: 0 = none, 1 = one |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Byte address of the word |
| req_seq | input | 1 | Master expects to read the next word next |
| rsp_ready | output | 1 | Request completes this cycle; data valid |
| rsp_data | output | 32 | Read word |
| b0_en | output | 1 | Bank 0 read enable |
| b0_row | output | ADDR_W-3 | Bank 0 row address |
| b0_data | input | 32 | Bank 0 read data |
| b1_en | output | 1 | Bank 1 read enable |
| b1_row | output | ADDR_W-3 | Bank 1 row address |
| b1_data | input | 32 | Bank 1 read data |

## Verification
The assertions assume the master keeps `req_valid`, `req_addr` and `req_seq` unchanged from the first cycle of a request until the cycle in which `rsp_ready` is high. They also assume `cfg_wait1` changes only while no request is pending. The stimulus keeps to both rules. It drives each request right after a clock edge, holds it until completion, and changes the wait-state setting only during idle cycles. The bench's flash model returns a poison word whenever the one-wait-state access time is not met. Any early completion therefore also shows up as a data error.

// File: rtl/ilv_flash_pkg.sv
package ilv_flash_pkg;
    localparam int FL_DATA_W = 32;
    localparam int FL_BANKS  = 2;

    typedef logic [FL_DATA_W-1:0] fl_word_t;

    typedef enum logic {
        FL_MODE_NOWAIT = 1'b0,
        FL_MODE_WAIT1  = 1'b1
    } fl_mode_e;
endpackage

// File: rtl/ilv_addr_split.sv
module ilv_addr_split #(
    parameter int ADDR_W = 16,
    localparam int WORD_W = ADDR_W - 2,
    localparam int ROW_W  = ADDR_W - 3
) (
    input  logic [WORD_W-1:0] word_idx,
    output logic              cur_bank,
    output logic [ROW_W-1:0]  cur_row,
    output logic [ROW_W-1:0]  nxt_row
);
    logic [WORD_W-1:0] nxt_word;

    always_comb begin
        nxt_word = word_idx + WORD_W'(1);
        cur_bank = word_idx[0];
        cur_row  = word_idx[WORD_W-1:1];
        nxt_row  = nxt_word[WORD_W-1:1];
    end
endmodule

// File: rtl/ilv_bank_port.sv
module ilv_bank_port #(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             present,
    input  logic [ROW_W-1:0] row_in,
    output logic             bank_en,
    output logic [ROW_W-1:0] bank_row
);
    typedef struct packed {
        logic             en;
        logic [ROW_W-1:0] row;
    } port_st_t;

    port_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (present) begin
            st_d.en  = 1'b1;
            st_d.row = row_in;
        end
        bank_en  = st_d.en;
        bank_row = st_d.row;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ilv_prefetch_ctl.sv
module ilv_prefetch_ctl
    import ilv_flash_pkg::*;
#(
    parameter int WORD_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wait1,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] req_word,
    input  logic              req_seq,
    output logic              rsp_ready,
    output logic              pf_on
);
    typedef struct packed {
        logic              pf_valid;
        logic [WORD_W-1:0] pf_word;
        logic              waited;
    } pf_st_t;

    pf_st_t   st_d, st_q;
    fl_mode_e mode;
    logic     hit;

    always_comb begin
        mode      = fl_mode_e'(cfg_wait1);
        hit       = (mode == FL_MODE_WAIT1) && st_q.pf_valid && (req_word == st_q.pf_word);
        rsp_ready = req_valid && ((mode == FL_MODE_NOWAIT) || hit || st_q.waited);
        pf_on     = req_valid && req_seq && (mode == FL_MODE_WAIT1);

        st_d = st_q;
        if (mode == FL_MODE_NOWAIT) begin
            st_d.pf_valid = 1'b0;
            st_d.waited   = 1'b0;
        end else if (req_valid) begin
            if (rsp_ready) begin
                st_d.waited   = 1'b0;
                st_d.pf_valid = req_seq;
                st_d.pf_word  = req_word + WORD_W'(1);
            end else begin
                st_d.waited   = 1'b1;
                st_d.pf_valid = 1'b0;
            end
        end else begin
            st_d.waited = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ilv_flash_rd.sv
module ilv_flash_rd
    import ilv_flash_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int WORD_W = ADDR_W - 2,
    localparam int ROW_W  = ADDR_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wait1,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_seq,
    output logic              rsp_ready,
    output logic [31:0]       rsp_data,
    output logic              b0_en,
    output logic [ROW_W-1:0]  b0_row,
    input  logic [31:0]       b0_data,
    output logic              b1_en,
    output logic [ROW_W-1:0]  b1_row,
    input  logic [31:0]       b1_data
);
    logic              cur_bank;
    logic [ROW_W-1:0]  cur_row, nxt_row;
    logic              pf_on;
    logic [FL_BANKS-1:0] present;
    logic [FL_BANKS-1:0] bank_en;
    logic [ROW_W-1:0]  row_in   [FL_BANKS];
    logic [ROW_W-1:0]  bank_row [FL_BANKS];
    fl_word_t          bank_dat [FL_BANKS];

    ilv_addr_split #(.ADDR_W(ADDR_W)) u_split (
        .word_idx (req_addr[ADDR_W-1:2]),
        .cur_bank (cur_bank),
        .cur_row  (cur_row),
        .nxt_row  (nxt_row)
    );

    ilv_prefetch_ctl #(.WORD_W(WORD_W)) u_pf (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wait1 (cfg_wait1),
        .req_valid (req_valid),
        .req_word  (req_addr[ADDR_W-1:2]),
        .req_seq   (req_seq),
        .rsp_ready (rsp_ready),
        .pf_on     (pf_on)
    );

    for (genvar gi = 0; gi < FL_BANKS; gi++) begin : g_bank
        always_comb begin
            if (cur_bank == gi[0]) begin
                present[gi] = req_valid;
                row_in[gi]  = cur_row;
            end else begin
                present[gi] = pf_on;
                row_in[gi]  = nxt_row;
            end
        end

        ilv_bank_port #(.ROW_W(ROW_W)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .present  (present[gi]),
            .row_in   (row_in[gi]),
            .bank_en  (bank_en[gi]),
            .bank_row (bank_row[gi])
        );
    end

    always_comb begin
        bank_dat[0] = b0_data;
        bank_dat[1] = b1_data;
        b0_en       = bank_en[0];
        b0_row      = bank_row[0];
        b1_en       = bank_en[1];
        b1_row      = bank_row[1];
        rsp_data    = bank_dat[cur_bank];
    end
endmodule

// File: rtl/ilv_flash_rd_chk.sv
module ilv_flash_rd_chk #(
    parameter int ADDR_W = 16,
    localparam int ROW_W = ADDR_W - 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wait1,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_seq,
    input logic              rsp_ready,
    input logic              b0_en,
    input logic [ROW_W-1:0]  b0_row,
    input logic              b1_en,
    input logic [ROW_W-1:0]  b1_row
);
    assert_ready_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !rsp_ready);

    assert_nowait_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_wait1) |-> rsp_ready);

    assert_wait_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_wait1 && !rsp_ready) |=> (!req_valid || !cfg_wait1 || rsp_ready));

    assert_no_seq_no_pf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wait1 && rsp_ready && !req_seq) |=> (!cfg_wait1 || !rsp_ready));

    assert_burst_rate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wait1 && rsp_ready && req_seq) ##1
        (cfg_wait1 && req_valid && req_addr == ADDR_W'($past(req_addr) + ADDR_W'(4)))
        |-> rsp_ready);

    assert_bank0_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wait1 && rsp_ready && !req_addr[2]) |->
        (b0_en && $past(b0_en) && b0_row == $past(b0_row)));

    assert_bank1_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wait1 && rsp_ready && req_addr[2]) |->
        (b1_en && $past(b1_en) && b1_row == $past(b1_row)));
endmodule

bind ilv_flash_rd ilv_flash_rd_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wait1 (cfg_wait1),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_seq   (req_seq),
    .rsp_ready (rsp_ready),
    .b0_en     (b0_en),
    .b0_row    (b0_row),
    .b1_en     (b1_en),
    .b1_row    (b1_row)
);

// File: tb/ilv_flash_rd_tb.sv
`timescale 1ns/1ps
module ilv_flash_rd_tb;
    localparam int AW = 16;
    localparam int RW = AW - 3;
    localparam logic [31:0] POISON = 32'hDEAD_BEEF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wait1 = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_seq = 1'b0;
    logic          rsp_ready;
    logic [31:0]   rsp_data;
    logic          b0_en, b1_en;
    logic [RW-1:0] b0_row, b1_row;
    logic [31:0]   b0_data, b1_data;

    int    checks = 0;
    int    fails = 0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    ilv_flash_rd #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wait1(cfg_wait1),
        .req_valid(req_valid), .req_addr(req_addr), .req_seq(req_seq),
        .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .b0_en(b0_en), .b0_row(b0_row), .b0_data(b0_data),
        .b1_en(b1_en), .b1_row(b1_row), .b1_data(b1_data)
    );

    function automatic logic [31:0] word_of(input int w);
        logic [15:0] v;
        v = 16'(w);
        return {v ^ 16'h5A3C, ~v};
    endfunction

    // Behavioural flash: with one wait state, data is valid only when the row was held since the last edge.
    logic          p0_en = 1'b0, p1_en = 1'b0;
    logic [RW-1:0] p0_row = '0, p1_row = '0;
    always @(posedge clk) begin
        p0_en <= b0_en; p0_row <= b0_row;
        p1_en <= b1_en; p1_row <= b1_row;
    end
    assign b0_data = (cfg_wait1 && !(b0_en && p0_en && p0_row == b0_row)) ? POISON : word_of(2 * int'(b0_row));
    assign b1_data = (cfg_wait1 && !(b1_en && p1_en && p1_row == b1_row)) ? POISON : word_of(2 * int'(b1_row) + 1);

    task automatic check(input logic ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Reference model, compared every cycle.
    bit m_pf_valid = 0;
    int m_pf_word  = 0;
    bit m_waited   = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            check(rsp_ready == 1'b0, "R1", "ready in reset", rsp_ready, 0);
            m_pf_valid = 0; m_waited = 0;
        end else begin
            int  w;
            bit  hit, exp_rdy;
            w   = int'(req_addr[AW-1:2]);
            hit = cfg_wait1 && m_pf_valid && (w == m_pf_word);
            exp_rdy = req_valid && (!cfg_wait1 || hit || m_waited);
            check(rsp_ready == exp_rdy, cur_tag, "ready", rsp_ready, exp_rdy);
            if (exp_rdy && rsp_ready)
                check(rsp_data == word_of(w), {cur_tag, " R3 R9"}, "data", rsp_data, word_of(w));
            if (!cfg_wait1) begin
                m_pf_valid = 0; m_waited = 0;
            end else if (req_valid) begin
                if (exp_rdy) begin
                    m_waited = 0; m_pf_valid = req_seq; m_pf_word = (w + 1) % (1 << (AW - 2));
                end else begin
                    m_waited = 1; m_pf_valid = 0;
                end
            end else begin
                m_waited = 0;
            end
        end
    end

    task automatic issue(input logic [AW-1:0] a, input logic s, input int exp_lat, input string tag);
        int lat;
        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = a; req_seq = s; cur_tag = tag;
        lat = 0;
        forever begin
            @(negedge clk);
            lat++;
            if (rsp_ready || lat > 20) break;
        end
        check(lat == exp_lat, tag, "latency", lat, exp_lat);
    endtask

    task automatic idle(input int n);
        @(posedge clk); #1;
        req_valid = 1'b0; req_seq = 1'b0; cur_tag = "R1";
        repeat (n - 1) @(posedge clk);
    endtask

    task automatic set_mode(input logic m);
        idle(1);
        cfg_wait1 = m;
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", "timeout", 1, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);

        // R2, R3: no wait state, both banks
        set_mode(1'b0);
        issue(16'h0010, 1'b0, 1, "R2");
        issue(16'h0014, 1'b1, 1, "R3");
        issue(16'h0124, 1'b0, 1, "R3");
        issue(16'h0008, 1'b0, 1, "R2");
        idle(2);

        // R4: random accesses with one wait state
        set_mode(1'b1);
        issue(16'h0200, 1'b0, 2, "R4");
        issue(16'h0334, 1'b0, 2, "R4");
        idle(2);

        // R5: burst from bank 0
        issue(16'h0040, 1'b1, 2, "R5");
        for (int i = 1; i < 7; i++) issue(16'h0040 + 16'(4 * i), 1'b1, 1, "R5");
        issue(16'h005C, 1'b0, 1, "R5");
        idle(2);

        // R5: burst from bank 1 (crosses row)
        issue(16'h001C, 1'b1, 2, "R5");
        for (int i = 1; i < 5; i++) issue(16'h001C + 16'(4 * i), 1'b1, 1, "R5");
        idle(2);

        // R6: repeat and jump do not use the prefetch
        issue(16'h0080, 1'b1, 2, "R6");
        issue(16'h0080, 1'b1, 2, "R6");
        issue(16'h008C, 1'b1, 2, "R6");
        idle(2);

        // R7: a miss discards the pending prefetch
        issue(16'h00A0, 1'b1, 2, "R7");
        issue(16'h0300, 1'b0, 2, "R7");
        issue(16'h00A4, 1'b0, 2, "R7");
        idle(2);

        // R8: no hint, no prefetch
        issue(16'h00C0, 1'b0, 2, "R8");
        issue(16'h00C4, 1'b0, 2, "R8");
        idle(2);

        // R10: idle gap inside a burst
        issue(16'h00E4, 1'b1, 2, "R10");
        idle(3);
        issue(16'h00E8, 1'b1, 1, "R10");
        idle(4);
        issue(16'h00EC, 1'b0, 1, "R10");
        idle(2);

        // R11: no prefetch recorded in the no-wait mode
        set_mode(1'b0);
        issue(16'h0100, 1'b1, 1, "R11");
        set_mode(1'b1);
        issue(16'h0104, 1'b1, 2, "R11");
        issue(16'h0108, 1'b0, 1, "R11");
        idle(3);

        finish_run();
    end
endmodule